// File: doc/BRIEF.md
# Conditional Branch Target Unit

This unit settles control flow for one branch or jump at a time in a processor pipeline. It receives the address of the current instruction, the raw displacement fields taken straight from the instruction word, a 4-bit condition code and the five status flags (zero, sign, carry, overflow, saturated). From these it decides whether the branch is taken and produces the address of the next instruction.

Four kinds of operation are handled. A short conditional branch uses a 9-bit halfword-scaled displacement. A long relative jump uses a 22-bit displacement. A jump-and-link is a long relative jump that also returns the sequential address as a link value. A register-indirect jump goes to a register value. One short-branch form is degenerate: an always-taken branch whose displacement is zero would loop on itself forever. The unit reports this form as a trap request instead of branching.

The decision and the target are formed combinationally. With `REG_OUT` set (the default), the results are held in an output register and appear one clock after the operation is presented. Fetch, decode and register writeback sit outside the unit.

Top module: `brt_branch_unit`

## Requirements
- R1: The condition code selects the test. Code 0 is overflow set and code 1 is carry set. Code 2 is zero set and code 3 is carry or zero. Code 4 is sign set. Code 6 is sign xor overflow, and code 7 is (sign xor overflow) or zero. Codes 8, 9, A, B, C, E and F are the logical negations of codes 0, 1, 2, 3, 4, 6 and 7 respectively.
- R2: Code 5 is always met. Code D is met exactly when the saturated flag is set.
- R3: A short branch (op_kind_i = 0) forms its displacement from the bits {disp_hi_i[4:0], disp_lo_i[2:0], 0}. This 9-bit value is sign-extended. When the condition is met, taken_o = 1 and next_addr_o = cur_addr_i + displacement.
- R4: A short branch whose condition is not met gives taken_o = 0 and next_addr_o = cur_addr_i + 2.
- R5: A short branch with code 5, disp_hi_i[4:0] = 0 and disp_lo_i[2:0] = 0 gives trap_o = 1, taken_o = 0 and next_addr_o = cur_addr_i + 2. No other operation raises trap_o. In particular, code D or any other code with a zero displacement does not trap.
- R6: A long jump (op_kind_i = 1) is always taken. Its target is cur_addr_i plus the sign-extended 22-bit value {disp_hi_i[5:0], disp_lo_i[14:0], 0}.
- R7: A jump-and-link (op_kind_i = 2) jumps exactly as R6 does. It also gives link_valid_o = 1 and link_addr_o = cur_addr_i + 4. All other kinds give link_valid_o = 0 and link_addr_o = 0.
- R8: A register-indirect jump (op_kind_i = 3) is always taken, with next_addr_o equal to reg_addr_i with bit 0 cleared.
- R9: With REG_OUT = 1, the results of an operation appear on the outputs in the cycle after the clock edge that samples op_valid_i = 1. A cycle with op_valid_i = 0 yields valid_o = 0 and zero on every other output.
- R10: While rst_n is low, every output is zero.
- R11: For a short branch, disp_hi_i[5] and disp_lo_i[14:3] affect neither the target nor the trap decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid_i | input | 1 | An operation is presented this cycle |
| op_kind_i | input | 2 | 0 short branch, 1 long jump, 2 jump-and-link, 3 register-indirect |
| cond_i | input | 4 | Condition code for short branches |
| flag_z_i | input | 1 | Zero flag |
| flag_s_i | input | 1 | Sign flag |
| flag_cy_i | input | 1 | Carry flag |
| flag_ov_i | input | 1 | Overflow flag |
| flag_sat_i | input | 1 | Saturated flag |
| cur_addr_i | input | ADDR_W | Address of the current instruction |
| disp_hi_i | input | LONG_HI_W | Upper displacement field |
| disp_lo_i | input | LONG_LO_W | Lower displacement field |
| reg_addr_i | input | ADDR_W | Register value for indirect jumps |
| valid_o | output | 1 | Result valid |
| taken_o | output | 1 | Branch or jump taken |
| next_addr_o | output | ADDR_W | Next instruction address |
| trap_o | output | 1 | Branch-to-self trap request |
| link_valid_o | output | 1 | Link value valid |
| link_addr_o | output | ADDR_W | Return address for jump-and-link |

## Verification
The only state in the unit is its output register, so an error in it cannot build up over time. A wrong value shows on the ports in the cycle right after the operation that caused it, or as a missing clear in a following idle cycle. Wrong condition decoding shows as a flipped taken_o for a particular code and flag combination, which is why every code is run against every flag pattern. A wrong displacement field slice shows as a target off by a power of two, or as a trap that fires when the ignored bits are set.

// File: rtl/brt_pkg.sv
package brt_pkg;

    typedef enum logic [1:0] {
        KIND_SHORT = 2'd0,
        KIND_LONG  = 2'd1,
        KIND_LINK  = 2'd2,
        KIND_INDIR = 2'd3
    } jump_kind_e;

    typedef struct packed {
        logic z;
        logic s;
        logic cy;
        logic ov;
        logic sat;
    } flags_t;

    // code positions whose meaning the decoder depends on
    localparam logic [2:0] CC_BASE_OV   = 3'd0;
    localparam logic [2:0] CC_BASE_CY   = 3'd1;
    localparam logic [2:0] CC_BASE_Z    = 3'd2;
    localparam logic [2:0] CC_BASE_NH   = 3'd3;
    localparam logic [2:0] CC_BASE_S    = 3'd4;
    localparam logic [2:0] CC_BASE_SPEC = 3'd5;
    localparam logic [2:0] CC_BASE_LT   = 3'd6;
    localparam logic [2:0] CC_BASE_LE   = 3'd7;
    localparam logic [3:0] CC_ALWAYS    = 4'h5;

endpackage

// File: rtl/brt_cond_eval.sv
module brt_cond_eval
    import brt_pkg::*;
(
    input  logic [3:0] cond_i,
    input  flags_t     flags_i,
    output logic       met_o
);

    logic base_term;
    logic lt_term;

    always_comb begin
        lt_term = flags_i.s ^ flags_i.ov;
        unique case (cond_i[2:0])
            CC_BASE_OV:   base_term = flags_i.ov;
            CC_BASE_CY:   base_term = flags_i.cy;
            CC_BASE_Z:    base_term = flags_i.z;
            CC_BASE_NH:   base_term = flags_i.cy | flags_i.z;
            CC_BASE_S:    base_term = flags_i.s;
            CC_BASE_SPEC: base_term = 1'b1;
            CC_BASE_LT:   base_term = lt_term;
            CC_BASE_LE:   base_term = lt_term | flags_i.z;
            default:      base_term = 1'b0;
        endcase
        // upper half negates its partner, except the special slot
        if (cond_i[2:0] == CC_BASE_SPEC) begin
            met_o = cond_i[3] ? flags_i.sat : 1'b1;
        end else begin
            met_o = base_term ^ cond_i[3];
        end
    end

endmodule

// File: rtl/brt_disp_ext.sv
module brt_disp_ext #(
    parameter int HI_W  = 5,
    parameter int LO_W  = 3,
    parameter int OUT_W = 32
) (
    input  logic [HI_W-1:0]  hi_i,
    input  logic [LO_W-1:0]  lo_i,
    output logic [OUT_W-1:0] disp_o
);

    localparam int RAW_W = HI_W + LO_W + 1;
    localparam int PAD_W = OUT_W - RAW_W;

    logic [RAW_W-1:0] raw;

    always_comb begin
        raw    = {hi_i, lo_i, 1'b0};
        disp_o = {{PAD_W{raw[RAW_W-1]}}, raw};
    end

endmodule

// File: rtl/brt_branch_unit.sv
module brt_branch_unit
    import brt_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int SHORT_HI_W  = 5,
    parameter int SHORT_LO_W  = 3,
    parameter int LONG_HI_W   = 6,
    parameter int LONG_LO_W   = 15,
    parameter int SHORT_BYTES = 2,
    parameter int LONG_BYTES  = 4,
    parameter bit REG_OUT     = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 op_valid_i,
    input  logic [1:0]           op_kind_i,
    input  logic [3:0]           cond_i,
    input  logic                 flag_z_i,
    input  logic                 flag_s_i,
    input  logic                 flag_cy_i,
    input  logic                 flag_ov_i,
    input  logic                 flag_sat_i,
    input  logic [ADDR_W-1:0]    cur_addr_i,
    input  logic [LONG_HI_W-1:0] disp_hi_i,
    input  logic [LONG_LO_W-1:0] disp_lo_i,
    input  logic [ADDR_W-1:0]    reg_addr_i,
    output logic                 valid_o,
    output logic                 taken_o,
    output logic [ADDR_W-1:0]    next_addr_o,
    output logic                 trap_o,
    output logic                 link_valid_o,
    output logic [ADDR_W-1:0]    link_addr_o
);

    localparam logic [ADDR_W-1:0] STEP_SHORT = ADDR_W'(SHORT_BYTES);
    localparam logic [ADDR_W-1:0] STEP_LONG  = ADDR_W'(LONG_BYTES);

    typedef struct packed {
        logic              valid;
        logic              taken;
        logic              trap;
        logic              link_valid;
        logic [ADDR_W-1:0] next;
        logic [ADDR_W-1:0] link;
    } result_t;

    result_t    res_d;
    result_t    res_q;
    flags_t     flags;
    jump_kind_e kind;
    logic       cond_met;
    logic       self_loop;
    logic [ADDR_W-1:0] short_disp;
    logic [ADDR_W-1:0] long_disp;
    logic [ADDR_W-1:0] seq_addr;

    assign flags = '{z: flag_z_i, s: flag_s_i, cy: flag_cy_i,
                     ov: flag_ov_i, sat: flag_sat_i};
    assign kind  = jump_kind_e'(op_kind_i);

    brt_cond_eval u_cond (
        .cond_i  (cond_i),
        .flags_i (flags),
        .met_o   (cond_met)
    );

    brt_disp_ext #(
        .HI_W  (SHORT_HI_W),
        .LO_W  (SHORT_LO_W),
        .OUT_W (ADDR_W)
    ) u_short_disp (
        .hi_i   (disp_hi_i[SHORT_HI_W-1:0]),
        .lo_i   (disp_lo_i[SHORT_LO_W-1:0]),
        .disp_o (short_disp)
    );

    brt_disp_ext #(
        .HI_W  (LONG_HI_W),
        .LO_W  (LONG_LO_W),
        .OUT_W (ADDR_W)
    ) u_long_disp (
        .hi_i   (disp_hi_i),
        .lo_i   (disp_lo_i),
        .disp_o (long_disp)
    );

    // degenerate form: always-branch with both short fields zero
    assign self_loop = (cond_i == CC_ALWAYS)
                    && (disp_hi_i[SHORT_HI_W-1:0] == '0)
                    && (disp_lo_i[SHORT_LO_W-1:0] == '0);
    assign seq_addr  = cur_addr_i + STEP_SHORT;

    always_comb begin
        res_d = '0;
        if (op_valid_i) begin
            res_d.valid = 1'b1;
            unique case (kind)
                KIND_SHORT: begin
                    if (self_loop) begin
                        res_d.trap = 1'b1;
                        res_d.next = seq_addr;
                    end else if (cond_met) begin
                        res_d.taken = 1'b1;
                        res_d.next  = cur_addr_i + short_disp;
                    end else begin
                        res_d.next  = seq_addr;
                    end
                end
                KIND_LONG: begin
                    res_d.taken = 1'b1;
                    res_d.next  = cur_addr_i + long_disp;
                end
                KIND_LINK: begin
                    res_d.taken      = 1'b1;
                    res_d.next       = cur_addr_i + long_disp;
                    res_d.link_valid = 1'b1;
                    res_d.link       = cur_addr_i + STEP_LONG;
                end
                KIND_INDIR: begin
                    res_d.taken = 1'b1;
                    res_d.next  = {reg_addr_i[ADDR_W-1:1], 1'b0};
                end
                default: res_d = '0;
            endcase
        end
    end

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    res_q <= '0;
                end else begin
                    res_q <= res_d;
                end
            end

            p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
                op_valid_i |=> valid_o);

            p_fallthrough_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (op_valid_i && kind == KIND_SHORT) |=>
                    (taken_o || next_addr_o == $past(cur_addr_i) + STEP_SHORT));

            p_link_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (op_valid_i && kind == KIND_LINK) |=>
                    (link_addr_o == $past(cur_addr_i) + STEP_LONG));
        end else begin : g_comb
            assign res_q = rst_n ? res_d : '0;
        end
    endgenerate

    assign valid_o      = res_q.valid;
    assign taken_o      = res_q.taken;
    assign next_addr_o  = res_q.next;
    assign trap_o       = res_q.trap;
    assign link_valid_o = res_q.link_valid;
    assign link_addr_o  = res_q.link;

    p_trap_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> !taken_o);

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> (!taken_o && !trap_o && !link_valid_o));

    p_link_taken_r7: assert property (@(posedge clk) disable iff (!rst_n)
        link_valid_o |-> (taken_o && valid_o));

endmodule

// File: tb/brt_branch_unit_tb.sv
`timescale 1ns/1ps
module brt_branch_unit_tb_top;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [1:0]  kind;
        logic [3:0]  cc;
        logic [4:0]  fl;   // {z, s, cy, ov, sat}
        logic [5:0]  hi;
        logic [14:0] lo;
        logic [31:0] cur;
        logic [31:0] rv;
        logic        tk;
        logic [31:0] nx;
        logic        tr;
    } vec_t;

    localparam int NVEC = 14;
    localparam vec_t TBL [NVEC] = '{
        '{2'd0, 4'h2, 5'b10000, 6'h01, 15'h0002, 32'h1000, 32'h0, 1'b1, 32'h1014, 1'b0},
        '{2'd0, 4'h2, 5'b00000, 6'h01, 15'h0002, 32'h1000, 32'h0, 1'b0, 32'h1002, 1'b0},
        '{2'd0, 4'h5, 5'b00000, 6'h10, 15'h0000, 32'h2000, 32'h0, 1'b1, 32'h1F00, 1'b0},
        '{2'd0, 4'h5, 5'b00000, 6'h00, 15'h0000, 32'h3000, 32'h0, 1'b0, 32'h3002, 1'b1},
        '{2'd0, 4'h5, 5'b00000, 6'h20, 15'h7FF8, 32'h4000, 32'h0, 1'b0, 32'h4002, 1'b1},
        '{2'd0, 4'hF, 5'b01010, 6'h1F, 15'h0007, 32'h5000, 32'h0, 1'b1, 32'h4FFE, 1'b0},
        '{2'd1, 4'h0, 5'b00000, 6'h3F, 15'h7FFF, 32'h0100, 32'h0, 1'b1, 32'h00FE, 1'b0},
        '{2'd1, 4'h0, 5'b00000, 6'h01, 15'h0000, 32'h0100, 32'h0, 1'b1, 32'h10100, 1'b0},
        '{2'd2, 4'h0, 5'b00000, 6'h00, 15'h0010, 32'h0800, 32'h0, 1'b1, 32'h0820, 1'b0},
        '{2'd3, 4'h0, 5'b00000, 6'h00, 15'h0000, 32'h0900, 32'h12345677, 1'b1, 32'h12345676, 1'b0},
        '{2'd0, 4'hD, 5'b00001, 6'h00, 15'h0002, 32'h0600, 32'h0, 1'b1, 32'h0604, 1'b0},
        '{2'd0, 4'hD, 5'b00000, 6'h00, 15'h0002, 32'h0600, 32'h0, 1'b0, 32'h0602, 1'b0},
        '{2'd0, 4'h2, 5'b10000, 6'h00, 15'h0000, 32'h0700, 32'h0, 1'b1, 32'h0700, 1'b0},
        '{2'd0, 4'hD, 5'b00001, 6'h00, 15'h0000, 32'h0A00, 32'h0, 1'b1, 32'h0A00, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_kind = '0;
    logic [3:0]  cc = '0;
    logic [4:0]  fl = '0;
    logic [31:0] cur = '0;
    logic [5:0]  hi = '0;
    logic [14:0] lo = '0;
    logic [31:0] rv = '0;
    logic        valid_o, taken_o, trap_o, link_valid_o;
    logic [31:0] next_o, link_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    brt_branch_unit dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .op_valid_i   (op_valid),
        .op_kind_i    (op_kind),
        .cond_i       (cc),
        .flag_z_i     (fl[4]),
        .flag_s_i     (fl[3]),
        .flag_cy_i    (fl[2]),
        .flag_ov_i    (fl[1]),
        .flag_sat_i   (fl[0]),
        .cur_addr_i   (cur),
        .disp_hi_i    (hi),
        .disp_lo_i    (lo),
        .reg_addr_i   (rv),
        .valid_o      (valid_o),
        .taken_o      (taken_o),
        .next_addr_o  (next_o),
        .trap_o       (trap_o),
        .link_valid_o (link_valid_o),
        .link_addr_o  (link_o)
    );

    function automatic logic ref_cond(input logic [3:0] c, input logic [4:0] f);
        logic z, s, cy, ov, sat;
        {z, s, cy, ov, sat} = f;
        case (c)
            4'h0: return ov;
            4'h1: return cy;
            4'h2: return z;
            4'h3: return cy | z;
            4'h4: return s;
            4'h5: return 1'b1;
            4'h6: return s ^ ov;
            4'h7: return (s ^ ov) | z;
            4'h8: return !ov;
            4'h9: return !cy;
            4'hA: return !z;
            4'hB: return !(cy | z);
            4'hC: return !s;
            4'hD: return sat;
            4'hE: return !(s ^ ov);
            default: return !((s ^ ov) | z);
        endcase
    endfunction

    function automatic string kind_req(input logic [1:0] k);
        case (k)
            2'd0: return "R3";
            2'd1: return "R6";
            2'd2: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic [1:0] k, input logic [3:0] c, input logic [4:0] f,
                         input logic [5:0] h, input logic [14:0] l,
                         input logic [31:0] a, input logic [31:0] r);
        @(negedge clk);
        op_valid = 1'b1;
        op_kind  = k;
        cc       = c;
        fl       = f;
        hi       = h;
        lo       = l;
        cur      = a;
        rv       = r;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL R9 watchdog: actual hung expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R10: outputs zero while reset is low, even with an op presented
        op_valid = 1'b1;
        op_kind  = 2'd1;
        hi       = 6'h05;
        cur      = 32'h1234;
        repeat (3) @(posedge clk);
        #1;
        check("R10", "valid", {31'b0, valid_o}, 32'h0);
        check("R10", "taken", {31'b0, taken_o}, 32'h0);
        check("R10", "next", next_o, 32'h0);
        check("R10", "trap/link", {30'b0, trap_o, link_valid_o}, 32'h0);
        check("R10", "link", link_o, 32'h0);
        @(negedge clk);
        op_valid = 1'b0;
        rst_n    = 1'b1;

        // table walk: R3 R4 R5 R6 R8 R11 and R2 boundary codes
        for (int i = 0; i < NVEC; i++) begin
            apply(TBL[i].kind, TBL[i].cc, TBL[i].fl, TBL[i].hi, TBL[i].lo,
                  TBL[i].cur, TBL[i].rv);
            check(kind_req(TBL[i].kind), $sformatf("vec%0d valid", i), {31'b0, valid_o}, 32'h1);
            check(kind_req(TBL[i].kind), $sformatf("vec%0d taken", i), {31'b0, taken_o}, {31'b0, TBL[i].tk});
            check(kind_req(TBL[i].kind), $sformatf("vec%0d next", i), next_o, TBL[i].nx);
            check("R5", $sformatf("vec%0d trap", i), {31'b0, trap_o}, {31'b0, TBL[i].tr});
        end

        // R1 R2: every code against every flag combination; disp = 4
        for (int c = 0; c < 16; c++) begin
            for (int f = 0; f < 32; f++) begin
                logic exp_tk;
                exp_tk = ref_cond(4'(c), 5'(f));
                apply(2'd0, 4'(c), 5'(f), 6'h00, 15'h0002, 32'h1000, 32'h0);
                check((c == 5 || c == 13) ? "R2" : "R1",
                      $sformatf("cc%0h fl%05b taken", c, f),
                      {31'b0, taken_o}, {31'b0, exp_tk});
                check(exp_tk ? "R3" : "R4", $sformatf("cc%0h fl%05b next", c, f),
                      next_o, exp_tk ? 32'h1004 : 32'h1002);
            end
        end

        // R7: link value on jump-and-link, none on other kinds
        apply(2'd2, 4'h0, 5'b0, 6'h3F, 15'h7FFE, 32'h8000, 32'h0);
        check("R7", "link valid", {31'b0, link_valid_o}, 32'h1);
        check("R7", "link addr", link_o, 32'h8004);
        check("R7", "jal next", next_o, 32'h7FFC);
        // R9: outputs hold until the next edge after new inputs
        @(negedge clk);
        op_kind = 2'd1;
        #1;
        check("R9", "hold before edge", link_o, 32'h8004);
        @(posedge clk);
        #1;
        check("R7", "no link on long", {31'b0, link_valid_o}, 32'h0);
        check("R7", "link zero on long", link_o, 32'h0);
        apply(2'd3, 4'h0, 5'b0, 6'h0, 15'h0, 32'h0, 32'hFFFF_FFFE);
        check("R8", "even reg kept", next_o, 32'hFFFF_FFFE);
        check("R7", "no link on indirect", {31'b0, link_valid_o}, 32'h0);

        // R9: idle cycle clears all outputs
        @(negedge clk);
        op_valid = 1'b0;
        @(posedge clk);
        #1;
        check("R9", "idle valid", {31'b0, valid_o}, 32'h0);
        check("R9", "idle taken", {31'b0, taken_o}, 32'h0);
        check("R9", "idle next", next_o, 32'h0);
        check("R9", "idle trap/link", {30'b0, trap_o, link_valid_o}, 32'h0);

        // R11: ignored upper bits on a short taken branch
        apply(2'd0, 4'h5, 5'b0, 6'h21, 15'h7FF9, 32'h2000, 32'h0);
        check("R11", "ignored bits next", next_o, 32'h2012);
        check("R11", "ignored bits trap", {31'b0, trap_o}, 32'h0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule